// File: doc/BRIEF.md
# Cascadable Serial Bitstream Reader

This block is the read side of a one-bit-wide serial memory that feeds a configuration bitstream to a programmable-logic device running as a serial master. The device supplies the clock. On each rising edge while the reader is selected and enabled, the reader steps to the next stored bit. The current bit is presented on a data line that can go to high impedance. The data line is modelled as a value plus a separate drive-enable, so several readers can share one line.

Select, reset/output-enable and serial-enable are inputs. A stored polarity bit decides which level of the reset/output-enable input clears the counter and which level enables the output. After the last stored bit has been read, the reader stops driving and lowers its cascade output. That output feeds the select input of the next reader in a chain, so the bitstream continues without a gap. A synchronous load port fills the bit array and the polarity bit.

Top module: `cfg_stream_rom`

## Requirements
- R1: After rst_ni is released, the bit counter is 0, the polarity bit is 1, data_oe_o is 0 while ce_ni is high, and ceo_no is 1.
- R2: With ser_en_i=1, ce_ni=0 and the output enabled, data_o shows stored bit k, and each rising edge moves to bit k+1. Reading starts at bit 0. DEPTH may be 65536, 131072 or 262144 bits.
- R3: data_oe_o is 1 exactly when all of the following hold: ser_en_i=1, ce_ni=0, rst_oe_i is at its enable level, and the end of memory has not been passed.
- R4: When rst_oe_i is at its reset level on a rising edge (ser_en_i=1), the counter returns to bit 0 and ceo_no returns to 1. This happens whatever the level of ce_ni.
- R5: Polarity bit 1 (pol_bit_i=1, written with pol_we_i) makes rst_oe_i=1 the reset level and rst_oe_i=0 the enable level. Polarity bit 0 reverses both.
- R6: While ce_ni=1 and rst_oe_i is at its enable level, the counter holds and data_oe_o is 0.
- R7: On the edge that reads bit DEPTH-1, the counter saturates and does not wrap. From the next cycle, ceo_no is 0 and data_oe_o is 0.
- R8: After the end, ceo_no stays 0 until ce_ni is sampled high at an edge. From then on, ceo_no equals ce_ni. Once the reset level is sampled, ceo_no is 1 until another full pass completes.
- R9: While ser_en_i=0, data_oe_o is 0 and ceo_no is 1. The counter and cascade state hold, and ce_ni has no effect.
- R10: When one reader's ceo_no drives the next reader's ce_ni on a shared line, at most one reader drives in any cycle. The second reader drives its bit 0 in the cycle after the first reader reads its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock from the configured device |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_en_i | input | 1 | Read mode when high |
| ce_ni | input | 1 | Active-low select |
| rst_oe_i | input | 1 | Combined reset and output-enable, polarity set by the stored bit |
| ld_we_i | input | 1 | Write strobe for the bit array |
| ld_addr_i | input | AW | Bit address to write |
| ld_bit_i | input | 1 | Bit value to write |
| pol_we_i | input | 1 | Write strobe for the polarity bit |
| pol_bit_i | input | 1 | Polarity value: 1 means a high rst_oe_i is the reset level |
| data_o | output | 1 | Current stored bit |
| data_oe_o | output | 1 | Drive enable for data_o |
| ceo_no | output | 1 | Active-low cascade select to the next reader |

## Verification
The bench chains two readers on one line and reads through the hand-off. A reader that wrapped its counter or kept driving past its last bit would collide with its neighbour, and a reader with a one-cycle skew in the hand-off would leave a gap or a duplicate in the stream. The bench raises the select input during the post-end hold. A design that let the cascade output follow the select input too early, or not at all, would enable the second reader at the wrong time. The bench also flips the polarity bit and resets mid-stream under each polarity, which catches an inverted or ignored enable level. It drops serial-enable while toggling select, which catches a counter that still moves or a line that is still driven.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_HOLD  = 2'd1,
    CS_TRACK = 2'd2
  } casc_st_e;
endpackage

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  input  logic          pol_wr_i,
  input  logic          pol_bit_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_bit_o,
  output logic          pol_o
);
  logic [DEPTH-1:0] mem_q;
  logic             pol_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= 1'b1;
    else if (pol_wr_i) pol_q <= pol_bit_i;
  end

  assign rd_bit_o = mem_q[rd_addr_i];
  assign pol_o    = pol_q;
endmodule

// File: rtl/cfg_bit_ctr.sv
module cfg_bit_ctr #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   addr_q <= '0;
    else if (clr_i)                addr_q <= '0;
    else if (adv_i && !at_last_o)  addr_q <= addr_q + 1'b1;
  end

  assign at_last_o = (addr_q == LAST);
  assign addr_o    = addr_q;
endmodule

// File: rtl/cfg_casc_fsm.sv
module cfg_casc_fsm
  import cfg_stream_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     oe_act_i,
  input  logic     ce_ni,
  input  logic     last_read_i,
  output casc_st_e st_o,
  output logic     ceo_no
);
  casc_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (active_i) begin
      if (!oe_act_i) st_d = CS_IDLE;
      else begin
        unique case (st_q)
          CS_IDLE:  if (last_read_i) st_d = CS_HOLD;
          CS_HOLD:  if (ce_ni) st_d = CS_TRACK;
          CS_TRACK: st_d = CS_TRACK;
          default:  st_d = CS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CS_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    if (!active_i) ceo_no = 1'b1;
    else begin
      unique case (st_q)
        CS_HOLD:  ceo_no = 1'b0;
        CS_TRACK: ceo_no = ce_ni;
        default:  ceo_no = 1'b1;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ser_en_i,
  input  logic          ce_ni,
  input  logic          rst_oe_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_bit_i,
  input  logic          pol_we_i,
  input  logic          pol_bit_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          ceo_no
);
  logic          pol;
  logic          oe_act;
  logic          rd_bit;
  logic [AW-1:0] addr;
  logic          at_last;
  logic          idle;
  logic          adv;
  logic          clr;
  casc_st_e      st;

  // polarity 1: high level resets, low level enables output
  assign oe_act = pol ? !rst_oe_i : rst_oe_i;
  assign clr    = ser_en_i && !oe_act;
  assign idle   = (st == CS_IDLE);
  assign adv    = ser_en_i && oe_act && !ce_ni && idle;

  cfg_bit_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ld_we_i),
    .wr_addr_i (ld_addr_i),
    .wr_bit_i  (ld_bit_i),
    .pol_wr_i  (pol_we_i),
    .pol_bit_i (pol_bit_i),
    .rd_addr_i (addr),
    .rd_bit_o  (rd_bit),
    .pol_o     (pol)
  );

  cfg_bit_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .adv_i     (adv),
    .addr_o    (addr),
    .at_last_o (at_last)
  );

  cfg_casc_fsm u_casc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (ser_en_i),
    .oe_act_i    (oe_act),
    .ce_ni       (ce_ni),
    .last_read_i (adv && at_last),
    .st_o        (st),
    .ceo_no      (ceo_no)
  );

  assign data_oe_o = adv;
  assign data_o    = adv ? rd_bit : 1'b0;
endmodule

// File: rtl/cfg_stream_rom_chk.sv
module cfg_stream_rom_chk
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ser_en_i,
  input logic          ce_ni,
  input logic          oe_act,
  input logic [AW-1:0] addr,
  input casc_st_e      st,
  input logic          data_oe_o,
  input logic          ceo_no
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_DRIVE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ser_en_i && !ce_ni && oe_act)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && !oe_act) |=> (addr == '0 && ceo_no)); // R4
  AST_STANDBY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && ce_ni && oe_act) |=> $stable(addr)); // R6
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && oe_act && addr == LAST) |=> (addr == LAST)); // R7
  AST_CEO_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && oe_act && !ce_ni && addr == LAST && st == CS_IDLE)
      |=> (!data_oe_o && (!ser_en_i || !ceo_no || !oe_act))); // R7
  AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != CS_IDLE) |-> !data_oe_o); // R7
  AST_SER_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |=> ($stable(addr) && $stable(st))); // R9
  AST_SER_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> (!data_oe_o && ceo_no)); // R9
endmodule

bind cfg_stream_rom cfg_stream_rom_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ser_en_i  (ser_en_i),
  .ce_ni     (ce_ni),
  .oe_act    (oe_act),
  .addr      (addr),
  .st        (st),
  .data_oe_o (data_oe_o),
  .ceo_no    (ceo_no)
);

// File: tb/cfg_stream_rom_test.sv
module cfg_stream_rom_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b1, ce = 1'b1, rsto = 1'b1;
  logic we_a = 1'b0, we_b = 1'b0, ld_bit = 1'b0, pol_we = 1'b0, pol_bit = 1'b1;
  logic [AW-1:0] ld_addr = '0;
  logic d_a, oe_a, ceo_a, d_b, oe_b, ceo_b;

  always #2.5 clk = ~clk;

  cfg_stream_rom #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser), .ce_ni(ce), .rst_oe_i(rsto),
    .ld_we_i(we_a), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
    .pol_we_i(pol_we), .pol_bit_i(pol_bit),
    .data_o(d_a), .data_oe_o(oe_a), .ceo_no(ceo_a));

  cfg_stream_rom #(.DEPTH(DEPTH)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser), .ce_ni(ceo_a), .rst_oe_i(rsto),
    .ld_we_i(we_b), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
    .pol_we_i(pol_we), .pol_bit_i(pol_bit),
    .data_o(d_b), .data_oe_o(oe_b), .ceo_no(ceo_b));

  int total = 0, bad = 0;
  bit done_flag = 0;
  string cur = "R2";

  bit img [2][DEPTH];
  int m_addr [2];
  int m_st [2];   // 0 idle, 1 hold, 2 track
  bit m_pol [2];
  bit m_drv [2];
  bit m_ceo [2];

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit oe_lvl(int i, bit r);
    return m_pol[i] ? !r : r;
  endfunction

  function automatic void model_comb(int i, bit cei);
    m_drv[i] = ser && !cei && oe_lvl(i, rsto) && m_st[i] == 0;
    if (!ser)              m_ceo[i] = 1'b1;
    else if (m_st[i] == 0) m_ceo[i] = 1'b1;
    else if (m_st[i] == 1) m_ceo[i] = 1'b0;
    else                   m_ceo[i] = cei;
  endfunction

  function automatic void model_step(int i, bit cei);
    if (ser) begin
      if (!oe_lvl(i, rsto)) begin
        m_addr[i] = 0; m_st[i] = 0;
      end else if (m_st[i] == 0) begin
        if (!cei) begin
          if (m_addr[i] == DEPTH - 1) m_st[i] = 1;
          else m_addr[i]++;
        end
      end else if (m_st[i] == 1) begin
        if (cei) m_st[i] = 2;
      end
    end
    if (pol_we) m_pol[i] = pol_bit;
  endfunction

  task automatic cyc(bit s, bit c, bit r);
    bit ce_b_m;
    @(negedge clk);
    ser = s; ce = c; rsto = r;
    #1;
    model_comb(0, ce);
    ce_b_m = m_ceo[0];
    model_comb(1, ce_b_m);
    chk(cur, "a.oe", oe_a, m_drv[0]);
    if (m_drv[0]) chk(cur, "a.data", d_a, img[0][m_addr[0]]);
    chk(cur, "a.ceo", ceo_a, m_ceo[0]);
    chk(cur, "b.oe", oe_b, m_drv[1]);
    if (m_drv[1]) chk(cur, "b.data", d_b, img[1][m_addr[1]]);
    chk(cur, "b.ceo", ceo_b, m_ceo[1]);
    chk("R10", "contention", int'(oe_a && oe_b), 0);
    model_step(0, ce);
    model_step(1, ce_b_m);
    pol_we = 1'b0;
  endtask

  task automatic run(int n, bit s, bit c, bit r);
    for (int k = 0; k < n; k++) cyc(s, c, r);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_addr[i] = 0; m_st[i] = 0; m_pol[i] = 1'b1;
    end
    for (int k = 0; k < DEPTH; k++) begin
      img[0][k] = bit'(((k * 5 + 3) >> 2) ^ k);
      img[1][k] = bit'((k * 3 + 1) >> 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "oe after reset", oe_a, 0);
    chk("R1", "ceo after reset", ceo_a, 1);
    chk("R1", "b oe after reset", oe_b, 0);

    // load both images under reset level, deselected
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      ld_addr = AW'(k); ld_bit = img[0][k]; we_a = 1'b1; we_b = 1'b0;
      @(negedge clk);
      ld_bit = img[1][k]; we_a = 1'b0; we_b = 1'b1;
    end
    @(negedge clk);
    we_b = 1'b0;

    cur = "R4"; run(2, 1, 0, 1);
    cur = "R2"; run(20, 1, 0, 0);
    cur = "R6"; run(5, 1, 1, 0);
    cur = "R4"; run(1, 1, 0, 1);
    cur = "R2"; run(10, 1, 0, 0);
    cur = "R6"; run(3, 1, 1, 0);
    cur = "R7"; run(DEPTH, 1, 0, 0);
    cur = "R10"; run(20, 1, 0, 0);
    cur = "R8"; run(3, 1, 1, 0);
    run(2, 1, 0, 0);
    run(1, 1, 1, 0);
    run(DEPTH, 1, 0, 0);
    cur = "R9";
    for (int k = 0; k < 8; k++) cyc(0, k[0], k[1]);
    cur = "R8"; run(3, 1, 0, 0);
    cur = "R4"; run(2, 1, 1, 1);
    cur = "R2"; run(5, 1, 0, 0);

    // switch polarity: low level resets
    cur = "R5";
    @(negedge clk); pol_bit = 1'b0; pol_we = 1'b1;
    cyc(1, 1, 1);
    run(2, 1, 0, 0);
    run(12, 1, 0, 1);
    run(1, 1, 0, 0);
    run(6, 1, 0, 1);
    run(3, 1, 1, 1);
    cur = "R9"; run(4, 0, 0, 0);
    cur = "R5"; run(DEPTH + 4, 1, 0, 1);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule